// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache that sits on a shared snooping bus. Each line stores a tag and a two-bit coherence state (Invalid, Shared, Exclusive, Modified). Local processor reads and writes arrive on a request/done handshake. Snooped bus reads and snooped writes (read-for-ownership) arrive from the bus monitor. The block updates the line states and answers each snoop in the cycle it is presented. It reports whether it holds the snooped line, and whether that line is dirty and must be pushed onto the bus.

When a local access needs the bus, the controller raises one bus request at a time: a line fill, a fill that also invalidates other copies, an invalidate broadcast, or a write-back of a dirty victim. It holds the request until the bus acknowledges it. Another cache's snoop-hit signal, sampled with the fill acknowledge, decides whether a read fill ends Exclusive or Shared. A local access completes only after every bus transaction it needs has been acknowledged. A snoop always goes ahead of local work.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (`cpuLineState` = 0 for any address), `busReq` is low and `cpuDone` is low.
- R2: A read miss to a line that is not dirty raises `busReq` with `busCmd` = 1 (fill) and `busAddr` = the request address. `cpuDone` pulses in the acknowledge cycle. The line becomes Shared (1) if `busShared` is high in that cycle and Exclusive (2) otherwise.
- R3: A read hit in Shared, Exclusive or Modified completes in its first cycle with no bus request and leaves the state unchanged.
- R4: A write hit in Exclusive or Modified completes in its first cycle with no bus request and leaves the line Modified (3).
- R5: A write hit in Shared issues an invalidate (`busCmd` = 3) for that address. `cpuDone` is withheld until the acknowledge cycle, and the line then becomes Modified.
- R6: A write miss to a line that is not dirty issues a fill-with-invalidate (`busCmd` = 2) for the request address and ends Modified.
- R7: A snooped read (`snpWrite` = 0) that hits asserts `snpHit`. A Modified line also asserts `snpDirty` (push) and becomes Shared. An Exclusive line becomes Shared, and a Shared line stays Shared.
- R8: A snooped write (`snpWrite` = 1) that hits asserts `snpHit` and moves the line to Invalid. `snpDirty` is high only if the line was Modified.
- R9: A snoop whose address misses (tag mismatch or line Invalid) keeps `snpHit` and `snpDirty` low and changes no state.
- R10: A miss whose indexed line is Modified with another tag first issues a write-back (`busCmd` = 4) with the victim's address (old tag, same index). The fill or fill-with-invalidate for the new address follows.
- R11: In a cycle with `snpValid` high, the local side makes no progress: no `cpuDone`, no new bus request, and `busAck` is disregarded.
- R12: If a snooped write invalidates the line while its Shared-to-Modified invalidate is still pending, the acknowledge does not complete the write. A fill-with-invalidate is issued instead, and the line ends Modified.
- R13: Once raised, `busReq`, `busCmd` and `busAddr` stay unchanged until an acknowledge is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Local request, held until `cpuDone` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Line address, index in the low bits |
| cpuDone | output | 1 | Local request completes this cycle |
| cpuLineState | output | 2 | State of the line matching `cpuAddr` (0 I, 1 S, 2 E, 3 M) |
| snpValid | input | 1 | Snooped bus transaction present |
| snpWrite | input | 1 | 1 = snooped write/ownership, 0 = snooped read |
| snpAddr | input | ADDR_W | Snooped line address |
| snpHit | output | 1 | This cache holds the snooped line |
| snpDirty | output | 1 | Snooped line is Modified; data is pushed |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 3 | 0 none, 1 fill, 2 fill-invalidate, 3 invalidate, 4 write-back |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busAck | input | 1 | Bus accepts the current request |
| busShared | input | 1 | Another cache holds the filled line (sampled with `busAck`) |

## Verification
A scripted walk drives one line through every state with each kind of access: local reads and writes, snooped reads and writes, a clean fill and a fill that another cache shares. The walk also covers a conflict miss on a dirty line. Each step reads the resulting state through `cpuLineState` or the snoop response, and checks the bus commands and how many cycles the access took. This separates Exclusive from Shared, silent upgrades from invalidating ones, and write-back-then-fill from a plain fill. Directed cases then present a snoop together with a pending local access, and with an acknowledge, to show the snoop wins. They also cover a snooped write that arrives while an invalidate is outstanding, which must turn the upgrade into an ownership fill.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_E = 2'd2,
    LN_M = 2'd3
  } lineSt_t;

  typedef enum logic [2:0] {
    BC_NONE     = 3'd0,
    BC_FILL     = 3'd1,
    BC_FILL_INV = 3'd2,
    BC_INVAL    = 3'd3,
    BC_WRBACK   = 3'd4
  } busCmd_t;

  // control -> datapath: rewrite the line addressed by the local request
  typedef struct packed {
    logic    wrLine;
    lineSt_t newSt;
  } lineStrobe_t;

  // next state of a line that a snoop hits
  function automatic lineSt_t snoopNext(input lineSt_t cur, input logic isWrite);
    if (isWrite)      return LN_I;
    else if (cur == LN_I) return LN_I;
    else              return LN_S;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  lineStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                snpValid,
  input  logic                snpWrite,
  input  logic [ADDR_W-1:0]   snpAddr,
  output lineSt_t             lkState,
  output lineSt_t             victimState,
  output logic [ADDR_W-$clog2(LINES)-1:0] victimTag,
  output logic                snpHit,
  output logic                snpDirty
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineSt_t          stArr  [LINES];
  logic [TAG_W-1:0] tagArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpMatch;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // local lookup
  assign victimState = stArr[cpuIdx];
  assign victimTag   = tagArr[cpuIdx];
  assign lkState     = (stArr[cpuIdx] != LN_I && tagArr[cpuIdx] == cpuTag) ? stArr[cpuIdx] : LN_I;

  // snoop lookup
  assign snpMatch = snpValid && stArr[snpIdx] != LN_I && tagArr[snpIdx] == snpTag;
  assign snpHit   = snpMatch;
  assign snpDirty = snpMatch && stArr[snpIdx] == LN_M;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lineSt_t          st;
    logic [TAG_W-1:0] tg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= LN_I;
        tg <= '0;
      end else if (strobe.wrLine && cpuIdx == IDX_W'(g)) begin
        st <= strobe.newSt;
        tg <= cpuTag;
      end else if (snpMatch && snpIdx == IDX_W'(g)) begin
        st <= snoopNext(st, snpWrite);
      end
    end

    assign stArr[g]  = st;
    assign tagArr[g] = tg;
  end

endmodule

// File: rtl/mesi_line_fsm.sv
module mesi_line_fsm
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              snpValid,
  input  logic              busAck,
  input  logic              busShared,
  input  lineSt_t           lkState,
  input  lineSt_t           victimState,
  input  logic [ADDR_W-$clog2(LINES)-1:0] victimTag,
  output lineStrobe_t       strobe,
  output logic              cpuDone,
  output logic              busReq,
  output busCmd_t           busCmd,
  output logic [ADDR_W-1:0] busAddr
);
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [1:0] {F_IDLE, F_WBACK, F_FETCH, F_UPGR} fsmSt_t;

  fsmSt_t            stQ, stN;
  busCmd_t           cmdQ, cmdN;
  logic [ADDR_W-1:0] addrQ, addrN;
  logic              ackTaken;

  // a snoop in the same cycle blocks local progress
  assign ackTaken = busAck && !snpValid;

  always_comb begin
    stN     = stQ;
    cmdN    = cmdQ;
    addrN   = addrQ;
    strobe  = '0;
    cpuDone = 1'b0;
    case (stQ)
      F_IDLE: begin
        if (cpuReq && !snpValid) begin
          if (lkState != LN_I) begin
            if (!cpuWrite) begin
              cpuDone = 1'b1;
            end else if (lkState == LN_S) begin
              stN   = F_UPGR;
              cmdN  = BC_INVAL;
              addrN = cpuAddr;
            end else begin
              cpuDone       = 1'b1;
              strobe.wrLine = 1'b1;
              strobe.newSt  = LN_M;
            end
          end else if (victimState == LN_M) begin
            stN   = F_WBACK;
            cmdN  = BC_WRBACK;
            addrN = {victimTag, cpuAddr[IDX_W-1:0]};
          end else begin
            stN   = F_FETCH;
            cmdN  = cpuWrite ? BC_FILL_INV : BC_FILL;
            addrN = cpuAddr;
          end
        end
      end
      F_WBACK: begin
        if (ackTaken) begin
          strobe.wrLine = 1'b1;
          strobe.newSt  = LN_I;
          stN   = F_FETCH;
          cmdN  = cpuWrite ? BC_FILL_INV : BC_FILL;
          addrN = cpuAddr;
        end
      end
      F_FETCH: begin
        if (ackTaken) begin
          strobe.wrLine = 1'b1;
          strobe.newSt  = cpuWrite ? LN_M : (busShared ? LN_S : LN_E);
          cpuDone = 1'b1;
          stN     = F_IDLE;
          cmdN    = BC_NONE;
        end
      end
      F_UPGR: begin
        if (ackTaken) begin
          if (lkState == LN_S) begin
            strobe.wrLine = 1'b1;
            strobe.newSt  = LN_M;
            cpuDone = 1'b1;
            stN     = F_IDLE;
            cmdN    = BC_NONE;
          end else begin
            // copy lost to a snooped write while waiting: take ownership by fill
            stN   = F_FETCH;
            cmdN  = BC_FILL_INV;
            addrN = cpuAddr;
          end
        end
      end
      default: stN = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= F_IDLE;
      cmdQ  <= BC_NONE;
      addrQ <= '0;
    end else begin
      stQ   <= stN;
      cmdQ  <= cmdN;
      addrQ <= addrN;
    end
  end

  assign busReq  = (stQ != F_IDLE);
  assign busCmd  = cmdQ;
  assign busAddr = addrQ;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic [1:0]        cpuLineState,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic              snpDirty,
  output logic              busReq,
  output logic [2:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic              busShared
);
  localparam int TAG_W = ADDR_W - $clog2(LINES);

  lineStrobe_t      strobe;
  lineSt_t          lkState, victimState;
  logic [TAG_W-1:0] victimTag;
  busCmd_t          cmd;

  mesi_line_store #(.LINES(LINES), .ADDR_W(ADDR_W)) i_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuAddr     (cpuAddr),
    .snpValid    (snpValid),
    .snpWrite    (snpWrite),
    .snpAddr     (snpAddr),
    .lkState     (lkState),
    .victimState (victimState),
    .victimTag   (victimTag),
    .snpHit      (snpHit),
    .snpDirty    (snpDirty)
  );

  mesi_line_fsm #(.LINES(LINES), .ADDR_W(ADDR_W)) i_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .snpValid    (snpValid),
    .busAck      (busAck),
    .busShared   (busShared),
    .lkState     (lkState),
    .victimState (victimState),
    .victimTag   (victimTag),
    .strobe      (strobe),
    .cpuDone     (cpuDone),
    .busReq      (busReq),
    .busCmd      (cmd),
    .busAddr     (busAddr)
  );

  assign busCmd       = cmd;
  assign cpuLineState = lkState;

endmodule

// File: rtl/mesi_line_checker.sv
module mesi_line_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuDone,
  input logic              snpValid,
  input logic              snpHit,
  input logic              snpDirty,
  input logic              busReq,
  input logic [2:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck
);

  a_r11_snoop_blocks_done: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !cpuDone);

  a_r7_push_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    snpDirty |-> snpHit);

  a_r9_hit_needs_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snpHit |-> snpValid);

  a_r2_done_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq);

  a_r13_req_has_cmd: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busCmd != 3'd0 && busCmd <= 3'd4));

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !(busAck && !snpValid)) |=> (busReq && $stable(busCmd) && $stable(busAddr)));

  a_r10_wb_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd == 3'd4 && busAck && !snpValid) |=> (busReq && (busCmd == 3'd1 || busCmd == 3'd2)));

  a_r5_inval_no_done: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd == 3'd3 && !busAck) |-> !cpuDone);

endmodule

bind mesi_line_ctrl mesi_line_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuDone  (cpuDone),
  .snpValid (snpValid),
  .snpHit   (snpHit),
  .snpDirty (snpDirty),
  .busReq   (busReq),
  .busCmd   (busCmd),
  .busAddr  (busAddr),
  .busAck   (busAck)
);

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuReq, cpuWrite;
  logic [7:0] cpuAddr;
  logic       cpuDone;
  logic [1:0] cpuLineState;
  logic       snpValid, snpWrite;
  logic [7:0] snpAddr;
  logic       snpHit, snpDirty;
  logic       busReq;
  logic [2:0] busCmd;
  logic [7:0] busAddr;
  logic       busAck, busShared;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  mesi_line_ctrl i_mesi_line_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuDone(cpuDone), .cpuLineState(cpuLineState),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .snpHit(snpHit), .snpDirty(snpDirty),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr),
    .busAck(busAck), .busShared(busShared)
  );

  // op: 0 local read, 1 local write, 2 snooped read, 3 snooped write
  // fields: op[28:27] addr[26:19] shared[18] cmd1[17:15] cmd2[14:12]
  //         state[11:10] hit[9] dirty[8] victim[7:0]
  localparam int NV = 18;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 8'h11, 1'b0, 3'd1, 3'd0, 2'd2, 1'b0, 1'b0, 8'h00},
    {2'd0, 8'h11, 1'b0, 3'd0, 3'd0, 2'd2, 1'b0, 1'b0, 8'h00},
    {2'd1, 8'h11, 1'b0, 3'd0, 3'd0, 2'd3, 1'b0, 1'b0, 8'h00},
    {2'd2, 8'h11, 1'b0, 3'd0, 3'd0, 2'd1, 1'b1, 1'b1, 8'h00},
    {2'd1, 8'h11, 1'b0, 3'd3, 3'd0, 2'd3, 1'b0, 1'b0, 8'h00},
    {2'd3, 8'h11, 1'b0, 3'd0, 3'd0, 2'd0, 1'b1, 1'b1, 8'h00},
    {2'd0, 8'h22, 1'b1, 3'd1, 3'd0, 2'd1, 1'b0, 1'b0, 8'h00},
    {2'd2, 8'h22, 1'b0, 3'd0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00},
    {2'd3, 8'h22, 1'b0, 3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 8'h00},
    {2'd1, 8'h33, 1'b0, 3'd2, 3'd0, 2'd3, 1'b0, 1'b0, 8'h00},
    {2'd0, 8'h3B, 1'b0, 3'd4, 3'd1, 2'd2, 1'b0, 1'b0, 8'h33},
    {2'd2, 8'h33, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00},
    {2'd1, 8'h3B, 1'b0, 3'd0, 3'd0, 2'd3, 1'b0, 1'b0, 8'h00},
    {2'd0, 8'h44, 1'b0, 3'd1, 3'd0, 2'd2, 1'b0, 1'b0, 8'h00},
    {2'd2, 8'h44, 1'b0, 3'd0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00},
    {2'd3, 8'h55, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00},
    {2'd0, 8'h3B, 1'b0, 3'd0, 3'd0, 2'd3, 1'b0, 1'b0, 8'h00},
    {2'd1, 8'h13, 1'b0, 3'd4, 3'd2, 2'd3, 1'b0, 1'b0, 8'h3B}
  };

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [1:0] st);
    @(negedge clk);
    cpuReq = 1'b0; cpuAddr = a;
    #5 st = cpuLineState;
  endtask

  task automatic snoopOp(input bit w, input logic [7:0] a, output bit hit, output bit dirty);
    @(negedge clk);
    snpValid = 1'b1; snpWrite = w; snpAddr = a;
    #5 hit = snpHit; dirty = snpDirty;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic localOp(input bit wr, input logic [7:0] a, input bit sh,
                         output logic [2:0] c1, output logic [2:0] c2,
                         output logic [7:0] a1, output int cyc, output bit got);
    int nAck;
    c1 = '0; c2 = '0; a1 = '0; cyc = 0; nAck = 0; got = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; busShared = sh; busAck = 1'b0;
    for (int k = 0; k < 12 && !got; k++) begin
      #5 cyc++;
      if (busReq) begin
        if (nAck == 0) begin c1 = busCmd; a1 = busAddr; end
        else if (nAck == 1) c2 = busCmd;
        nAck++;
        busAck = 1'b1;
      end
      #1 if (cpuDone) got = 1;
      @(negedge clk);
      busAck = 1'b0;
    end
    cpuReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    logic [2:0] c1, c2;
    logic [7:0] a1;
    int cyc;
    bit got, hit, dirty;
    string tag;

    rstN = 1'b0; cpuReq = 0; cpuWrite = 0; cpuAddr = '0;
    snpValid = 0; snpWrite = 0; snpAddr = '0; busAck = 0; busShared = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 busReq in reset", busReq, 0);
    chk("R1 cpuDone in reset", cpuDone, 0);
    @(negedge clk) rstN = 1'b1;
    #5 chk("R1 busReq after reset", busReq, 0);
    peek(8'h11, st); chk("R1 line 0x11 invalid", st, 0);
    peek(8'h3B, st); chk("R1 line 0x3B invalid", st, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] ad;
      op = VEC[i][28:27];
      ad = VEC[i][26:19];
      if (op < 2) begin
        localOp(op[0], ad, VEC[i][18], c1, c2, a1, cyc, got);
        if (op == 0) tag = (VEC[i][17:15] == 3'd0) ? "R3" : (VEC[i][17:15] == 3'd4) ? "R10" : "R2";
        else tag = (VEC[i][17:15] == 3'd0) ? "R4" : (VEC[i][17:15] == 3'd3) ? "R5" :
                   (VEC[i][17:15] == 3'd4) ? "R10" : "R6";
        chk({tag, " completes"}, got, 1);
        chk({tag, " first bus cmd"}, c1, VEC[i][17:15]);
        chk({tag, " second bus cmd"}, c2, VEC[i][14:12]);
        if (VEC[i][17:15] == 3'd4) chk({tag, " victim address"}, a1, VEC[i][7:0]);
        else if (VEC[i][17:15] != 3'd0) chk({tag, " bus address"}, a1, ad);
        if (VEC[i][17:15] == 3'd0) chk({tag, " single-cycle hit"}, cyc, 1);
        if (VEC[i][17:15] == 3'd3) chk({tag, " done at invalidate ack"}, cyc, 2);
      end else begin
        snoopOp(op[0], ad, hit, dirty);
        tag = (op == 2) ? (VEC[i][9] ? "R7" : "R9") : (VEC[i][9] ? "R8" : "R9");
        chk({tag, " snoop hit"}, hit, VEC[i][9]);
        chk({tag, " snoop dirty"}, dirty, VEC[i][8]);
      end
      peek(ad, st);
      chk({tag, " final state"}, st, VEC[i][11:10]);
    end

    // R11: snoop in the same cycle as a read hit delays completion
    @(negedge clk);
    cpuReq = 1; cpuWrite = 0; cpuAddr = 8'h13;
    snpValid = 1; snpWrite = 0; snpAddr = 8'h77;
    #5 chk("R11 no done during snoop", cpuDone, 0);
    chk("R9 snoop miss", snpHit, 0);
    @(negedge clk) snpValid = 0;
    #5 chk("R11 done after snoop", cpuDone, 1);
    @(negedge clk) cpuReq = 0;
    peek(8'h13, st); chk("R3 modified read hit keeps M", st, 3);

    // R11/R13: acknowledge during a snoop is disregarded
    @(negedge clk);
    cpuReq = 1; cpuWrite = 0; cpuAddr = 8'h66; busShared = 1;
    @(negedge clk);
    #5 chk("R2 fill requested", busCmd, 1);
    busAck = 1; snpValid = 1; snpWrite = 0; snpAddr = 8'h01;
    #1 chk("R11 ack ignored under snoop", cpuDone, 0);
    @(negedge clk) busAck = 0; snpValid = 0;
    #5 chk("R13 request still raised", busReq, 1);
    chk("R13 command held", busCmd, 1);
    chk("R13 address held", busAddr, 8'h66);
    busAck = 1;
    #1 chk("R2 done on ack", cpuDone, 1);
    @(negedge clk) busAck = 0; cpuReq = 0; busShared = 0;
    peek(8'h66, st); chk("R2 shared fill", st, 1);

    // R12: line 0x44 is Shared; a snooped write arrives while invalidate pending
    @(negedge clk);
    cpuReq = 1; cpuWrite = 1; cpuAddr = 8'h44;
    @(negedge clk);
    #5 chk("R5 invalidate issued", busCmd, 3);
    chk("R5 invalidate address", busAddr, 8'h44);
    snpValid = 1; snpWrite = 1; snpAddr = 8'h44;
    #1 chk("R8 snoop write hits shared", snpHit, 1);
    @(negedge clk) snpValid = 0;
    #5 chk("R13 invalidate held", busCmd, 3);
    busAck = 1;
    #1 chk("R12 no done after lost copy", cpuDone, 0);
    @(negedge clk) busAck = 0;
    #5 chk("R12 fill-invalidate issued", busCmd, 2);
    busAck = 1;
    #1 chk("R12 done on fill ack", cpuDone, 1);
    @(negedge clk) busAck = 0; cpuReq = 0;
    peek(8'h44, st); chk("R12 ends modified", st, 3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule